// File: doc/BRIEF.md
# Fabric Orientation Configuration Sequencer

This block programs the orientation of every tile in a 64-tile reconfigurable logic fabric. The fabric has one serial scan chain through all its tiles and three sets of orientation latches per tile: diagonal, horizontal and vertical flip. A latch set takes the value in each tile's flip-flop while a 2-bit select input holds that set's code. The sequencer accepts three orientation vectors in one request. It then runs three phases. Each phase shifts one vector into the chain and strobes the matching latch set. At the end it signals completion.

A request is a single-cycle `start_i` while the block is idle. The vectors are captured at that moment. Every phase has the same shape: one idle-select cycle, then one bit per cycle for each tile, then the latch code for a fixed number of cycles. The select always returns to 00 between codes. The diagonal set is written first. A glitch on the select while it moves between 00 and 11 can briefly show 01 or 10. Writing the diagonal set first means any latch set hit by such a glitch is written again later in the sequence. Scan enable stays high through the whole sequence, which keeps the fabric in shift mode. It falls in the same cycle as the one-cycle `done_o` pulse.

Bit i of each vector belongs to the tile at chain position i. Position 0 is the tile that receives the scan input directly (top-left), and position 63 is the far end of the chain (bottom-right).

Top module: `fabric_cfg_loader`

## Requirements
- R1: When `rst` is held high at a clock edge, after that edge `busy_o`, `done_o`, `scan_en_o`, `scan_dat_o` and `cfg_sel_o` are all 0, whatever was in progress.
- R2: A `start_i` sampled high while idle is accepted. In the cycle after the accepting edge, `busy_o`=1, `scan_en_o`=1 and `cfg_sel_o`=00.
- R3: Each phase shifts exactly 64 bits, one per cycle, on `scan_dat_o`. Bit 63 of the vector is sent first and bit 0 last, so after the shift chain position i holds vector bit i.
- R4: The latch codes on `cfg_sel_o` are 11 for the diagonal set (`diag_i`), 10 for the horizontal set (`horiz_i`) and 01 for the vertical set (`vert_i`). They appear in exactly that order, once each per request.
- R5: Each code is held for exactly STROBE_CYC (2) consecutive cycles and starts in the cycle right after the last shifted bit. `cfg_sel_o` never changes from one nonzero code straight to another.
- R6: `cfg_sel_o` is 00 for GAP_CYC (1) cycle before each shift phase and for GAP_CYC cycle after the final 01 code.
- R7: From the cycle after acceptance until `done_o` rises, `scan_en_o` and `busy_o` stay 1. A nonzero `cfg_sel_o` only occurs while both are 1.
- R8: `done_o` is high for exactly one cycle. That cycle is 3*(GAP_CYC+64+STROBE_CYC)+GAP_CYC = 202 cycles after the accepting edge. In the same cycle `busy_o` and `scan_en_o` fall to 0.
- R9: A `start_i` pulse while `busy_o` is 1 is ignored. The loaded values and the completion cycle are unchanged, and the block is idle after `done_o`.
- R10: The vectors are captured at acceptance. Later changes on `diag_i`, `horiz_i` and `vert_i` do not affect the bits shifted in that request.
- R11: `scan_dat_o` is 0 in every cycle that is not a shift cycle, including whenever `scan_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| diag_i | input | 64 | Diagonal flip bits, bit i for chain position i |
| horiz_i | input | 64 | Horizontal flip bits, bit i for chain position i |
| vert_i | input | 64 | Vertical flip bits, bit i for chain position i |
| busy_o | output | 1 | High while a request is running |
| done_o | output | 1 | One-cycle completion pulse |
| scan_en_o | output | 1 | Fabric scan enable |
| scan_dat_o | output | 1 | Fabric scan chain data input |
| cfg_sel_o | output | 2 | Fabric latch select: 11 diagonal, 10 horizontal, 01 vertical, 00 hold |

## Verification
The assertions assume reset is applied from time zero, so the first history they see is the reset state. They also assume STROBE_CYC is at least 2, so that a code entered is still present one cycle later. They do not constrain `start_i`: the stimulus raises it both while idle and in the middle of a run. It also changes the vector inputs during a run, to show that only the acceptance-time values matter. Inputs change only at falling edges. The bench models the fabric's chain and latches from the port values alone, and each latch set takes the chain contents in the first cycle its code appears.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_GAP    = 2'd1,
    SQ_SHIFT  = 2'd2,
    SQ_STROBE = 2'd3
  } seq_state_t;

  localparam int NUM_SETS = 3;

  // Latch-set index to select code: diagonal, horizontal, vertical.
  function automatic logic [1:0] set_code(input logic [1:0] idx);
    case (idx)
      2'd0:    return 2'b11;
      2'd1:    return 2'b10;
      default: return 2'b01;
    endcase
  endfunction

endpackage

// File: rtl/fcl_bit_feed.sv
module fcl_bit_feed #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [WIDTH-1:0] vec_i,
  input  logic             pop_i,
  output logic             bit_o
);

  logic [WIDTH-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (load_i) begin
      shadow_q <= vec_i;
    end else if (pop_i) begin
      shadow_q <= {shadow_q[WIDTH-2:0], 1'b0};
    end
  end

  // Highest remaining bit goes out first.
  assign bit_o = shadow_q[WIDTH-1];

endmodule

// File: rtl/fcl_seq_ctrl.sv
module fcl_seq_ctrl
  import fcl_pkg::*;
#(
  parameter int TILES      = 64,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       scan_en_o,
  output logic [1:0] cfg_sel_o,
  output logic       load_o,
  output logic       pop_o,
  output logic [1:0] set_o
);

  localparam int MAX_A = (TILES > STROBE_CYC) ? TILES : STROBE_CYC;
  localparam int MAX_C = (MAX_A > GAP_CYC) ? MAX_A : GAP_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] SHIFT_LAST  = CNT_W'(TILES - 1);
  localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LAST    = CNT_W'(GAP_CYC - 1);
  localparam logic [1:0]       LAST_SET    = 2'(NUM_SETS - 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       set_q;
  logic             final_q;
  logic             gap_end, shift_end, strobe_end;

  always_comb begin
    gap_end    = (state_q == SQ_GAP)    && (cnt_q == GAP_LAST);
    shift_end  = (state_q == SQ_SHIFT)  && (cnt_q == SHIFT_LAST);
    strobe_end = (state_q == SQ_STROBE) && (cnt_q == STROBE_LAST);
    load_o     = (state_q == SQ_IDLE) && start_i;
    pop_o      = (gap_end && !final_q) || ((state_q == SQ_SHIFT) && !shift_end);
  end

  assign set_o = set_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_IDLE;
      cnt_q     <= '0;
      set_q     <= '0;
      final_q   <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      scan_en_o <= 1'b0;
      cfg_sel_o <= 2'b00;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            state_q   <= SQ_GAP;
            cnt_q     <= '0;
            set_q     <= '0;
            final_q   <= 1'b0;
            busy_o    <= 1'b1;
            scan_en_o <= 1'b1;
            cfg_sel_o <= 2'b00;
          end
        end
        SQ_GAP: begin
          if (gap_end) begin
            cnt_q <= '0;
            if (final_q) begin
              state_q   <= SQ_IDLE;
              busy_o    <= 1'b0;
              scan_en_o <= 1'b0;
              done_o    <= 1'b1;
            end else begin
              state_q <= SQ_SHIFT;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_SHIFT: begin
          if (shift_end) begin
            state_q   <= SQ_STROBE;
            cnt_q     <= '0;
            cfg_sel_o <= set_code(set_q);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_STROBE: begin
          if (strobe_end) begin
            state_q   <= SQ_GAP;
            cnt_q     <= '0;
            cfg_sel_o <= 2'b00;
            if (set_q == LAST_SET) final_q <= 1'b1;
            else                   set_q   <= set_q + 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  AST_SEL_VIA_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel_o != 2'b00 && $past(cfg_sel_o) != 2'b00) |-> cfg_sel_o == $past(cfg_sel_o)); // R5

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_sel_o) == 2'b00 && cfg_sel_o != 2'b00) |=> cfg_sel_o == $past(cfg_sel_o)); // R5

  AST_SEL_INSIDE_RUN: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel_o != 2'b00) |-> (busy_o && scan_en_o)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> (!busy_o && !scan_en_o && $past(busy_o) && cfg_sel_o == 2'b00)); // R8

endmodule

// File: rtl/fabric_cfg_loader.sv
module fabric_cfg_loader
  import fcl_pkg::*;
#(
  parameter int TILES      = 64,
  parameter int STROBE_CYC = 2,
  parameter int GAP_CYC    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [TILES-1:0] diag_i,
  input  logic [TILES-1:0] horiz_i,
  input  logic [TILES-1:0] vert_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             scan_en_o,
  output logic             scan_dat_o,
  output logic [1:0]       cfg_sel_o
);

  logic             load, pop;
  logic [1:0]       cur_set;
  logic [TILES-1:0] set_vec [NUM_SETS];
  logic [NUM_SETS-1:0] feed_bit;

  assign set_vec[0] = diag_i;
  assign set_vec[1] = horiz_i;
  assign set_vec[2] = vert_i;

  fcl_seq_ctrl #(
    .TILES(TILES), .STROBE_CYC(STROBE_CYC), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i),
    .busy_o(busy_o), .done_o(done_o), .scan_en_o(scan_en_o),
    .cfg_sel_o(cfg_sel_o), .load_o(load), .pop_o(pop), .set_o(cur_set)
  );

  for (genvar g = 0; g < NUM_SETS; g++) begin : g_feed
    fcl_bit_feed #(.WIDTH(TILES)) u_feed (
      .clk(clk), .rst(rst), .load_i(load), .vec_i(set_vec[g]),
      .pop_i(pop && (cur_set == 2'(g))), .bit_o(feed_bit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) scan_dat_o <= 1'b0;
    else     scan_dat_o <= pop ? feed_bit[cur_set] : 1'b0;
  end

  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !scan_en_o |-> !scan_dat_o); // R11

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> (busy_o || done_o)); // R9

endmodule

// File: tb/test_fabric_cfg_loader.sv
module test_fabric_cfg_loader;

  localparam int TILES  = 64;
  localparam int STROBE = 2;
  localparam int GAP    = 1;
  localparam int PERIOD = GAP + TILES + STROBE;
  localparam int DONE_T = 3 * PERIOD + GAP;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [TILES-1:0] diag_i = '0, horiz_i = '0, vert_i = '0;
  logic             busy_o, done_o, scan_en_o, scan_dat_o;
  logic [1:0]       cfg_sel_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  fabric_cfg_loader #(.TILES(TILES), .STROBE_CYC(STROBE), .GAP_CYC(GAP)) i_fabric_cfg_loader (
    .clk(clk), .rst(rst), .start_i(start_i),
    .diag_i(diag_i), .horiz_i(horiz_i), .vert_i(vert_i),
    .busy_o(busy_o), .done_o(done_o), .scan_en_o(scan_en_o),
    .scan_dat_o(scan_dat_o), .cfg_sel_o(cfg_sel_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // mode 0: plain; 1: extra start mid-run (R9); 2: inputs changed after acceptance (R10)
  task automatic run_load(input logic [TILES-1:0] d, h, v, input int mode, input string tag);
    logic [TILES-1:0] chain = '0, lat_d = '0, lat_h = '0, lat_v = '0;
    logic [1:0] prev_sel = 2'b00;
    logic [1:0] order [4];
    int n_codes = 0, run = 0, bad_len = 0, gap_bad = 0, en_bad = 0, quiet_bad = 0;
    int done_t = -1, done_cnt = 0, off;
    @(negedge clk);
    diag_i = d; horiz_i = h; vert_i = v; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && scan_en_o && cfg_sel_o == 2'b00, {"R2 accept ", tag},
        {61'd0, busy_o, cfg_sel_o}, 64'h4);
    for (int t = 0; t <= DONE_T + 5; t++) begin
      if (t > 0) @(negedge clk);
      off = t % PERIOD;
      if (cfg_sel_o != 2'b00 && prev_sel == 2'b00) begin
        if (n_codes < 4) order[n_codes] = cfg_sel_o;
        n_codes++;
        case (cfg_sel_o)
          2'b11:   lat_d = chain;
          2'b10:   lat_h = chain;
          default: lat_v = chain;
        endcase
      end
      if (cfg_sel_o != 2'b00) run++;
      else if (run != 0) begin
        if (run != STROBE) bad_len++;
        run = 0;
      end
      if (t < DONE_T && (!scan_en_o || !busy_o)) en_bad++;
      if (t < DONE_T && off < GAP && cfg_sel_o != 2'b00) gap_bad++;
      if (!(t < 3 * PERIOD && off >= GAP && off < GAP + TILES) && scan_dat_o) quiet_bad++;
      if (done_o) begin
        done_cnt++;
        done_t = t;
        chk(!busy_o && !scan_en_o, {"R8 release with done ", tag}, {62'd0, busy_o, scan_en_o}, 64'd0);
      end
      if (scan_en_o) chain = {chain[TILES-2:0], scan_dat_o};
      if (mode == 1 && t == 100) begin
        start_i = 1'b1; diag_i = ~d; horiz_i = ~h; vert_i = ~v;
      end
      if (mode == 1 && t == 101) start_i = 1'b0;
      if (mode == 2 && t == 5) begin
        diag_i = d ^ 64'hFFFF_0000_FFFF_0000; horiz_i = ~h; vert_i = h;
      end
      prev_sel = cfg_sel_o;
    end
    chk(lat_d == d, {"R3 diagonal set ", tag}, lat_d, d);
    chk(lat_h == h, {"R3 horizontal set ", tag}, lat_h, h);
    chk(lat_v == v, {"R3 vertical set ", tag}, lat_v, v);
    chk(n_codes == 3 && order[0] == 2'b11 && order[1] == 2'b10 && order[2] == 2'b01,
        {"R4 code order ", tag}, {54'd0, order[0], order[1], order[2], 4'(n_codes)},
        {54'd0, 2'b11, 2'b10, 2'b01, 4'd3});
    chk(bad_len == 0, {"R5 strobe length ", tag}, 64'(bad_len), 64'd0);
    chk(gap_bad == 0, {"R6 zero gaps ", tag}, 64'(gap_bad), 64'd0);
    chk(en_bad == 0, {"R7 enable held ", tag}, 64'(en_bad), 64'd0);
    chk(done_t == DONE_T && done_cnt == 1, {"R8 done timing ", tag}, 64'(done_t), 64'(DONE_T));
    chk(quiet_bad == 0, {"R11 data quiet ", tag}, 64'(quiet_bad), 64'd0);
    chk(!busy_o, {"R9 idle after run ", tag}, {63'd0, busy_o}, 64'd0);
  endtask

  task automatic test_reset_state();
    chk(!busy_o && !done_o && !scan_en_o && !scan_dat_o && cfg_sel_o == 2'b00, "R1 after reset",
        {59'd0, busy_o, done_o, scan_en_o, scan_dat_o, cfg_sel_o}, 64'd0);
  endtask

  task automatic test_reset_midrun();
    @(negedge clk);
    diag_i = 64'h0123_4567_89AB_CDEF; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (70) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy_o && !done_o && !scan_en_o && !scan_dat_o && cfg_sel_o == 2'b00, "R1 mid-run reset",
        {59'd0, busy_o, done_o, scan_en_o, scan_dat_o, cfg_sel_o}, 64'd0);
    repeat (3) @(negedge clk);
    chk(!busy_o, "R1 stays idle", {63'd0, busy_o}, 64'd0);
  endtask

  task automatic test_patterns();
    run_load(64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003, 64'hC000_0000_0000_0000, 0, "edges");
    run_load(64'hDEAD_BEEF_0123_4567, 64'h0F1E_2D3C_4B5A_6978, 64'h1357_9BDF_2468_ACE0, 0, "mixed");
    run_load(64'hFFFF_FFFF_FFFF_FFFE, 64'd0, 64'h5555_5555_AAAA_AAAA, 0, "dense");
  endtask

  task automatic test_start_while_busy();
    run_load(64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210, 64'h00FF_0F0F_3333_5A5A, 1, "R9 restart");
  endtask

  task automatic test_input_change();
    run_load(64'hA5A5_0000_1111_F00F, 64'h7777_8888_0001_8000, 64'h0000_0001_0000_0002, 2, "R10 late inputs");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R8 watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset_state();
    test_patterns();
    test_start_while_busy();
    test_input_change();
    test_reset_midrun();
    summary();
  end

endmodule